// File: doc/BRIEF.md
# TDM Serial Output Stream Driver

This block serializes per-channel bytes onto eight time-division-multiplexed output streams. Each clock cycle is one bit period. A frame holds 512 channels of 8 bits each, sent most significant bit first. A pulse marks the first bit of channel 0. Byte data comes from a simple read interface: the block puts out the index of the channel it will send next and takes one byte per stream from a wide data input.

Each stream output is a data bit paired with an output-enable bit, so a high-impedance pad can be modelled. A mode input, sampled while reset is held, picks how the outputs behave:
- **Mode low:** the outputs are driven high during initialization and stay driven afterwards.
- **Mode high:** the outputs float during initialization. Afterwards, each stream in each channel is driven only when a global drive-enable input and that channel's bit in an enable table are both set.

The enable table is loaded through a small write port. Both enable sources are latched at channel boundaries.

Top module: `tdm_out_driver`

## Requirements
- R1: After initialization, stream s sends bit 7-b of its channel-c byte in bit period b of channel c. There are 8 bit periods per channel and 512 channels per frame, so a frame repeats every 4096 clock cycles with no gap.
- R2: `frame_pulse` is high in exactly one cycle per frame: the bit period of bit 7 (the first bit sent) of channel 0. It is low during initialization.
- R3: `rd_chan` shows 0 during initialization and shows the index of the next channel while running. The byte for stream s is taken from `rd_data[8s+7:8s]` in the last bit period before that channel starts.
- R4: Initialization lasts while `rst_n` is low and for 16 clock cycles after its release. During initialization every `sdo` bit is 1.
- R5: When `reset_mode` was low during reset, every `sdo_oe` bit is 1 at all times, whatever `drive_en` and the table hold.
- R6: When `reset_mode` was high during reset, every `sdo_oe` bit is 0 during initialization.
- R7: In the high mode after initialization, `sdo_oe[s]` in channel c is 1 only if `drive_en` was 1 and bit s of table entry c was 1.
- R8: A write with `tbl_we` high stores `tbl_wdata` as the table entry `tbl_addr`. Bit s of the entry enables stream s. Reset clears every entry to 0.
- R9: Changes to `drive_en` or to the table take effect only from the next channel boundary. `sdo_oe` never changes within a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_mode | input | 1 | Output state mode, sampled during reset (0 driven, 1 high impedance) |
| drive_en | input | 1 | Global output drive enable |
| tbl_we | input | 1 | Enable-table write strobe |
| tbl_addr | input | 9 | Enable-table channel index |
| tbl_wdata | input | 8 | Per-stream enable bits for the addressed channel |
| rd_chan | output | 9 | Index of the channel whose bytes are requested |
| rd_data | input | 64 | One byte per stream for `rd_chan`, stream s in bits 8s+7:8s |
| sdo | output | 8 | Serial data, one bit per stream |
| sdo_oe | output | 8 | Output enable, one bit per stream |
| frame_pulse | output | 1 | High during the first bit of channel 0 |

## Verification
The bench runs six combinations of mode, global enable and enable-table content, and checks every bit period of a full frame for each. The combinations compare an all-ones table, an all-zero table and a table pattern that changes with the channel. With these, a gating term that ignores the mode, ignores the global enable or ignores the table each produces a different wrong `sdo_oe`. The source bytes differ for every stream and channel, so a swapped stream, a bit-order error or a channel offset shows up in `sdo`. Directed sequences change the enables in the middle of a channel and check that the table is cleared by reset.

// File: rtl/tdm_out_driver.sv
module tdm_out_driver #(
  parameter int STREAMS     = 8,
  parameter int CHANNELS    = 512,
  parameter int BITS        = 8,
  parameter int INIT_CYCLES = 16,
  localparam int CW = $clog2(CHANNELS),
  localparam int BW = $clog2(BITS),
  localparam int IW = $clog2(INIT_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reset_mode,
  input  logic                    drive_en,
  input  logic                    tbl_we,
  input  logic [CW-1:0]           tbl_addr,
  input  logic [STREAMS-1:0]      tbl_wdata,
  output logic [CW-1:0]           rd_chan,
  input  logic [STREAMS*BITS-1:0] rd_data,
  output logic [STREAMS-1:0]      sdo,
  output logic [STREAMS-1:0]      sdo_oe,
  output logic                    frame_pulse
);

  logic               mode_q, running, den_lat;
  logic [IW-1:0]      init_cnt;
  logic [BW-1:0]      bit_cnt;
  logic [CW-1:0]      chan_cnt, chan_nxt;
  logic [STREAMS-1:0] en_lat;
  logic [STREAMS-1:0] en_tab [CHANNELS];
  logic               last_bit, init_done, load;

  assign last_bit  = bit_cnt == BW'(BITS - 1);
  assign init_done = init_cnt == IW'(INIT_CYCLES - 1);
  assign chan_nxt  = (chan_cnt == CW'(CHANNELS - 1)) ? '0 : chan_cnt + 1'b1;
  assign rd_chan   = running ? chan_nxt : '0;
  assign load      = rst_n && (running ? last_bit : init_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= reset_mode;
      running  <= 1'b0;
      init_cnt <= '0;
      bit_cnt  <= '0;
      chan_cnt <= '0;
      en_lat   <= '0;
      den_lat  <= 1'b0;
    end else begin
      if (!running) begin
        init_cnt <= init_cnt + 1'b1;
        if (init_done) running <= 1'b1;
      end else begin
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit) chan_cnt <= chan_nxt;
      end
      if (load) begin
        en_lat  <= en_tab[rd_chan];
        den_lat <= drive_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CHANNELS; i++) en_tab[i] <= '0;
    end else if (tbl_we) begin
      en_tab[tbl_addr] <= tbl_wdata;
    end
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    logic [BITS-1:0] shreg;
    always_ff @(posedge clk) begin
      if (load)         shreg <= rd_data[s*BITS +: BITS];
      else if (running) shreg <= shreg << 1;
    end
    assign sdo[s] = running ? shreg[BITS-1] : 1'b1;
  end

  assign sdo_oe      = !mode_q ? '1 : ((running && den_lat) ? en_lat : '0);
  assign frame_pulse = running && bit_cnt == '0 && chan_cnt == '0;

endmodule

// File: rtl/tdm_out_driver_chk.sv
module tdm_out_driver_chk #(
  parameter int STREAMS = 8,
  parameter int BW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_q,
  input logic               running,
  input logic [BW-1:0]      bit_cnt,
  input logic [STREAMS-1:0] sdo,
  input logic [STREAMS-1:0] sdo_oe,
  input logic               frame_pulse
);

  // R4
  init_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (sdo == '1));

  // R5
  driven_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (sdo_oe == '1));

  // R6
  init_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !running) |-> (sdo_oe == '0));

  // R9
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bit_cnt != '0) |-> $stable(sdo_oe));

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);

  // R2
  pulse_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (running && bit_cnt == '0));

endmodule

bind tdm_out_driver tdm_out_driver_chk #(.STREAMS(STREAMS), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .running(running),
  .bit_cnt(bit_cnt), .sdo(sdo), .sdo_oe(sdo_oe), .frame_pulse(frame_pulse)
);

// File: tb/tdm_out_driver_test.sv
`timescale 1ns/1ps
module tdm_out_driver_test;
  localparam int INIT = 16;
  localparam int FRAME = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_mode = 1'b0, drive_en = 1'b0, tbl_we = 1'b0;
  logic [8:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [8:0] rd_chan;
  logic [63:0] rd_data;
  logic [7:0] sdo, sdo_oe;
  logic frame_pulse;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tdm_out_driver uut (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .drive_en(drive_en),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .rd_chan(rd_chan), .rd_data(rd_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .frame_pulse(frame_pulse)
  );

  function automatic logic [7:0] byte_of(int s, int c);
    return 8'((c * 29 + s * 83 + 60) ^ (c >> 3));
  endfunction

  function automatic logic [7:0] pat(int kind, int c);
    case (kind)
      0: return 8'hFF;
      1: return 8'h00;
      default: return 8'(c) ^ 8'hA5;
    endcase
  endfunction

  always_comb begin
    for (int s = 0; s < 8; s++) rd_data[s*8 +: 8] = byte_of(s, int'(rd_chan));
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic den);
    rst_n = 1'b0; reset_mode = mode; drive_en = den; tbl_we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 sdo in reset", sdo, 8'hFF);
    chk(mode ? "R6 oe in reset" : "R5 oe in reset", sdo_oe, mode ? 0 : 8'hFF);
    rst_n = 1'b1;
    for (int i = 0; i < INIT; i++) begin
      chk("R4 sdo during init", sdo, 8'hFF);
      chk(mode ? "R6 oe during init" : "R5 oe during init", sdo_oe, mode ? 0 : 8'hFF);
      chk("R2 pulse during init", frame_pulse, 0);
      chk("R3 rd_chan during init", rd_chan, 0);
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] exp_sdo(int k);
    logic [7:0] e;
    int c = (k >> 3) & 511;
    int b = k & 7;
    for (int s = 0; s < 8; s++) e[s] = byte_of(s, c)[7-b];
    return e;
  endfunction

  task automatic do_frame(input bit chk_oe, input bit wr, input logic mode,
                          input logic den, input int kind);
    for (int k = 0; k < FRAME; k++) begin
      int c = k >> 3;
      chk("R1 serial data", sdo, exp_sdo(k));
      chk("R2 frame pulse", frame_pulse, (k == 0) ? 1 : 0);
      chk("R3 rd_chan", rd_chan, (c + 1) % 512);
      if (chk_oe)
        chk(mode ? "R7 gated oe" : "R5 forced oe", sdo_oe,
            !mode ? 8'hFF : (den ? pat(kind, c) : 8'h00));
      if (wr && k < 512) begin
        tbl_we = 1'b1; tbl_addr = 9'(k); tbl_wdata = pat(kind, k);
      end else tbl_we = 1'b0;
      @(negedge clk);
    end
    tbl_we = 1'b0;
  endtask

  // {mode, drive_en, table kind[1:0]}
  localparam logic [3:0] VEC [6] = '{
    4'b0001, 4'b0110, 4'b1100, 4'b1000, 4'b1110, 4'b1101
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int v = 0; v < 6; v++) begin
      logic m = VEC[v][3];
      logic d = VEC[v][2];
      int kd = int'(VEC[v][1:0]);
      do_reset(m, d);
      do_frame(1'b0, 1'b1, m, d, kd);
      do_frame(1'b1, 1'b0, m, d, kd);
    end

    // R8: table cleared by reset, no writes afterwards
    do_reset(1'b1, 1'b1);
    do_frame(1'b1, 1'b0, 1'b1, 1'b1, 1);

    // R9: mid-channel changes apply from next channel only
    do_reset(1'b1, 1'b1);
    do_frame(1'b0, 1'b1, 1'b1, 1'b1, 0);
    for (int k = 0; k < 106 * 8; k++) begin
      int c = k >> 3;
      int b = k & 7;
      logic [7:0] e;
      case (c)
        101: e = 8'h0F;
        103, 104: e = 8'h00;
        default: e = 8'hFF;
      endcase
      chk("R9 oe at channel granularity", sdo_oe, e);
      chk("R1 serial data", sdo, exp_sdo(k));
      tbl_we = 1'b0;
      if (c == 100 && b == 2) begin tbl_we = 1'b1; tbl_addr = 9'd100; tbl_wdata = 8'h00; end
      if (c == 100 && b == 4) begin tbl_we = 1'b1; tbl_addr = 9'd101; tbl_wdata = 8'h0F; end
      if (c == 102 && b == 3) drive_en = 1'b0;
      if (c == 104 && b == 5) drive_en = 1'b1;
      @(negedge clk);
    end
    tbl_we = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule